// File: doc/BRIEF.md
# Trap Instruction Capture Register

This block keeps the encoding of the one instruction that will become the trap value of an illegal-instruction or virtual-instruction exception. Two sources can report such an instruction. The first is the CSR execution unit, which finds illegal accesses while it runs an instruction. The second is the decode stage, which flags encodings it cannot decode. Each source presents a valid bit, a 32-bit encoding and a flag that marks a 16-bit compressed instruction. The register takes at most one candidate and then holds it until a pipeline flush or a trap commit releases it. While it holds an entry it ignores every later candidate.

When both sources report in the same cycle, the CSR unit is served first, because its instruction is older in program order. A compressed instruction is stored without expansion: only its 16 low bits are kept and the upper half of the stored word is zero. On a trap commit the held encoding is offered as the trap value with a write enable. That write enable stays low while the hart is in debug mode, because a trap taken in debug mode must leave every trap value register unchanged.

The control is a two-state machine. The states are `ST_EMPTY` (no entry held) and `ST_HELD` (an entry is held). The transitions are:

- CAPTURE, from `ST_EMPTY` to `ST_HELD`: a candidate is valid and no clear is present.
- IDLE, staying in `ST_EMPTY`: no candidate is valid, or a clear is present.
- HOLD, staying in `ST_HELD`: no clear is present.
- RELEASE, from `ST_HELD` to `ST_EMPTY`: a flush or a trap commit is present.

Top module: `trap_inst_capture`

## Requirements
- R1: After reset `cap_vld` is 0 and `cap_enc` is 0.
- R2: When the register is empty, no clear is present and only the decode candidate is valid, `cap_vld` is 1 from the next clock edge. `cap_enc` then holds the decode encoding.
- R3: When the register is empty and both candidates are valid in the same cycle, the CSR candidate is the one captured.
- R4: While `cap_vld` is 1 and no clear is present, a new candidate from either source leaves `cap_enc` unchanged.
- R5: A candidate with its compressed flag set is stored as follows. `cap_enc[15:0]` takes `enc[15:0]`, and `cap_enc[31:16]` is 0.
- R6: A `flush` or `trap_commit` pulse makes `cap_vld` 0 and `cap_enc` 0 after the next clock edge. A candidate that arrives in the same cycle as the clear is dropped.
- R7: While `trap_commit` is 1, `cap_vld` is 1 and `dbg_mode` is 0, `tval_wen` is 1 in the same cycle and `tval_data` equals `cap_enc`. Otherwise `tval_wen` is 0.
- R8: While `dbg_mode` is 1, `tval_wen` is 0 regardless of `trap_commit`.
- R9: A CSR candidate without the compressed flag is stored with all 32 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_ill_vld | input | 1 | CSR unit reports an illegal instruction |
| csr_ill_enc | input | 32 | Encoding reported by the CSR unit |
| csr_ill_rvc | input | 1 | CSR candidate is a 16-bit compressed instruction |
| dec_ill_vld | input | 1 | Decode stage reports an illegal instruction |
| dec_ill_enc | input | 32 | Encoding reported by the decode stage |
| dec_ill_rvc | input | 1 | Decode candidate is a 16-bit compressed instruction |
| flush | input | 1 | Pipeline flush; releases the held entry |
| trap_commit | input | 1 | Trap commit; offers the trap value and releases the entry |
| dbg_mode | input | 1 | Hart is in debug mode |
| cap_vld | output | 1 | An entry is held |
| cap_enc | output | 32 | Held encoding, zero when empty |
| tval_wen | output | 1 | Write enable for the trap value register |
| tval_data | output | 32 | Trap value to be written |

## Verification
The assertions assume that the encoding bits of a compressed candidate above bit 15 may carry any value, so nothing checks those bits before storage. They also assume that `trap_commit` and `flush` are single-cycle pulses sampled on the same edge as the candidates. The stimulus respects both points. It changes every input only at the falling clock edge, puts non-zero garbage in the upper half of the compressed encodings, and raises each clear for exactly one cycle. In some of those cycles a candidate or `dbg_mode` is also presented, so that the clear-wins rule and the debug suppression both happen.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int INST_W = 32;
    localparam int RVC_W  = 16;
    localparam int NSRC   = 2;
    localparam int SRC_CSR = 0;
    localparam int SRC_DEC = 1;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic              vld;
        logic              rvc;
        logic [INST_W-1:0] enc;
    } cand_t;
endpackage

// File: rtl/tcr_fmt.sv
module tcr_fmt
    import tcr_pkg::*;
#(
    parameter int IW = INST_W,
    parameter int CW = RVC_W
) (
    input  cand_t  cand_in,
    output cand_t  cand_out
);
    localparam int PAD_W = IW - CW;

    always_comb begin
        cand_out = cand_in;
        if (cand_in.rvc) begin
            cand_out.enc = {{PAD_W{1'b0}}, cand_in.enc[CW-1:0]};
        end
    end
endmodule

// File: rtl/tcr_arb.sv
module tcr_arb
    import tcr_pkg::*;
#(
    parameter int N = NSRC
) (
    input  cand_t [N-1:0] cands,
    output cand_t         winner
);
    cand_t [N-1:0] fmt;

    for (genvar g = 0; g < N; g++) begin : g_fmt
        tcr_fmt u_fmt (
            .cand_in (cands[g]),
            .cand_out(fmt[g])
        );
    end

    // lower index = older in program order = higher priority
    always_comb begin
        winner = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fmt[i].vld) begin
                winner = fmt[i];
            end
        end
    end
endmodule

// File: rtl/tcr_fsm.sv
module tcr_fsm
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cand_t             cand,
    input  logic              clr,
    input  logic              commit,
    input  logic              dbg_mode,
    output logic              held,
    output logic [INST_W-1:0] data,
    output logic              wen,
    output logic [INST_W-1:0] wdata
);
    cap_state_e state_q, state_d;
    logic [INST_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (!clr && cand.vld) state_d = ST_HELD;
            ST_HELD:  if (clr)              state_d = ST_EMPTY;
            default:                        state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_EMPTY && state_d == ST_HELD) begin
                data_q <= cand.enc;
            end else if (state_d == ST_EMPTY) begin
                data_q <= '0;
            end
        end
    end

    always_comb begin
        held  = (state_q == ST_HELD);
        data  = data_q;
        wen   = held && commit && !dbg_mode;
        wdata = data_q;
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !clr) |=> (state_q == ST_HELD && $stable(data_q))); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_EMPTY && data_q == '0)); // R6
    AST_DEBUG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !wen); // R8
endmodule

// File: rtl/trap_inst_capture.sv
module trap_inst_capture
    import tcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_ill_vld,
    input  logic [31:0] csr_ill_enc,
    input  logic        csr_ill_rvc,
    input  logic        dec_ill_vld,
    input  logic [31:0] dec_ill_enc,
    input  logic        dec_ill_rvc,
    input  logic        flush,
    input  logic        trap_commit,
    input  logic        dbg_mode,
    output logic        cap_vld,
    output logic [31:0] cap_enc,
    output logic        tval_wen,
    output logic [31:0] tval_data
);
    cand_t [NSRC-1:0] cands;
    cand_t            winner;
    logic             clr;

    always_comb begin
        cands[SRC_CSR] = '{vld: csr_ill_vld, rvc: csr_ill_rvc, enc: csr_ill_enc};
        cands[SRC_DEC] = '{vld: dec_ill_vld, rvc: dec_ill_rvc, enc: dec_ill_enc};
        clr            = flush || trap_commit;
    end

    tcr_arb #(.N(NSRC)) u_arb (
        .cands (cands),
        .winner(winner)
    );

    tcr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (winner),
        .clr     (clr),
        .commit  (trap_commit),
        .dbg_mode(dbg_mode),
        .held    (cap_vld),
        .data    (cap_enc),
        .wen     (tval_wen),
        .wdata   (tval_data)
    );

    AST_CSR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_vld && !clr && csr_ill_vld && dec_ill_vld && !csr_ill_rvc)
        |=> (cap_vld && cap_enc == $past(csr_ill_enc))); // R3
    AST_DEC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_vld && !clr && !csr_ill_vld && dec_ill_vld && !dec_ill_rvc)
        |=> (cap_vld && cap_enc == $past(dec_ill_enc))); // R2
    AST_RVC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_vld && !clr && csr_ill_vld && csr_ill_rvc)
        |=> (cap_enc[31:16] == 16'h0 && cap_enc[15:0] == $past(csr_ill_enc[15:0]))); // R5
    AST_TVAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tval_wen |-> (cap_vld && trap_commit && tval_data == cap_enc)); // R7
endmodule

// File: tb/tb_trap_inst_capture.sv
module tb_trap_inst_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_ill_vld = 1'b0, csr_ill_rvc = 1'b0;
    logic [31:0] csr_ill_enc = '0;
    logic        dec_ill_vld = 1'b0, dec_ill_rvc = 1'b0;
    logic [31:0] dec_ill_enc = '0;
    logic        flush = 1'b0, trap_commit = 1'b0, dbg_mode = 1'b0;
    logic        cap_vld, tval_wen;
    logic [31:0] cap_enc, tval_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trap_inst_capture dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_ill_vld = 0; csr_ill_rvc = 0; csr_ill_enc = '0;
        dec_ill_vld = 0; dec_ill_rvc = 0; dec_ill_enc = '0;
        flush = 0; trap_commit = 0; dbg_mode = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic empty_it();
        idle(); flush = 1; step(); idle(); step();
    endtask

    task automatic t_reset();
        chk("R1 vld", {31'b0, cap_vld}, 32'd0);
        chk("R1 enc", cap_enc, 32'd0);
    endtask

    task automatic t_dec_only();
        empty_it();
        dec_ill_vld = 1; dec_ill_enc = 32'hDEAD_BEEF; step(); idle();
        chk("R2 vld", {31'b0, cap_vld}, 32'd1);
        chk("R2 enc", cap_enc, 32'hDEAD_BEEF);
    endtask

    task automatic t_csr_only();
        empty_it();
        csr_ill_vld = 1; csr_ill_enc = 32'h1234_5673; step(); idle();
        chk("R9 enc", cap_enc, 32'h1234_5673);
    endtask

    task automatic t_both();
        empty_it();
        csr_ill_vld = 1; csr_ill_enc = 32'hC5C5_0001;
        dec_ill_vld = 1; dec_ill_enc = 32'hDEC0_0002; step(); idle();
        chk("R3 csr wins", cap_enc, 32'hC5C5_0001);
    endtask

    task automatic t_no_overwrite();
        empty_it();
        dec_ill_vld = 1; dec_ill_enc = 32'h0000_AAAA; step(); idle();
        csr_ill_vld = 1; csr_ill_enc = 32'hFFFF_0000; step(); idle();
        chk("R4 csr ignored", cap_enc, 32'h0000_AAAA);
        dec_ill_vld = 1; dec_ill_enc = 32'h5555_5555; step(); idle();
        chk("R4 dec ignored", cap_enc, 32'h0000_AAAA);
        chk("R4 still held", {31'b0, cap_vld}, 32'd1);
    endtask

    task automatic t_rvc();
        empty_it();
        dec_ill_vld = 1; dec_ill_rvc = 1; dec_ill_enc = 32'hABCD_8001; step(); idle();
        chk("R5 dec rvc", cap_enc, 32'h0000_8001);
        empty_it();
        csr_ill_vld = 1; csr_ill_rvc = 1; csr_ill_enc = 32'h7777_4142;
        dec_ill_vld = 1; dec_ill_enc = 32'h9999_9999; step(); idle();
        chk("R5 csr rvc", cap_enc, 32'h0000_4142);
    endtask

    task automatic t_clear();
        empty_it();
        dec_ill_vld = 1; dec_ill_enc = 32'h0BAD_0BAD; step(); idle();
        flush = 1; step(); idle();
        chk("R6 flush vld", {31'b0, cap_vld}, 32'd0);
        chk("R6 flush enc", cap_enc, 32'd0);
        flush = 1; csr_ill_vld = 1; csr_ill_enc = 32'h1111_2222; step(); idle();
        chk("R6 dropped", {31'b0, cap_vld}, 32'd0);
        trap_commit = 1; dec_ill_vld = 1; dec_ill_enc = 32'h3333_4444; step(); idle();
        chk("R6 commit drop", {31'b0, cap_vld}, 32'd0);
    endtask

    task automatic t_commit();
        empty_it();
        trap_commit = 1; #1;
        chk("R7 empty no wen", {31'b0, tval_wen}, 32'd0);
        step(); idle();
        csr_ill_vld = 1; csr_ill_enc = 32'hFEED_F00D; step(); idle();
        chk("R7 no commit", {31'b0, tval_wen}, 32'd0);
        trap_commit = 1; #1;
        chk("R7 wen", {31'b0, tval_wen}, 32'd1);
        chk("R7 data", tval_data, 32'hFEED_F00D);
        step(); idle();
        chk("R6 after commit", {31'b0, cap_vld}, 32'd0);
    endtask

    task automatic t_debug();
        empty_it();
        dec_ill_vld = 1; dec_ill_enc = 32'h00C0_FFEE; step(); idle();
        trap_commit = 1; dbg_mode = 1; #1;
        chk("R8 no wen", {31'b0, tval_wen}, 32'd0);
        step(); idle();
        chk("R8 released", {31'b0, cap_vld}, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        step(); step();
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_dec_only();
        t_csr_only();
        t_both();
        t_no_overwrite();
        t_rvc();
        t_clear();
        t_commit();
        t_debug();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule